// File: doc/BRIEF.md
# Context exchange sequencer

This block carries out a hardware context switch through a fixed-size packet in memory. When it is started with an exchange address, it first reads all sixteen 64-bit packet words into a private holding buffer. It then writes the processor's present register state back to the same sixteen memory locations. Only after the last write has been accepted does it present the buffered packet to the register file as the new live state.

Sixteen words hold the packet. Words 8 to 15 hold the scalar registers in full. Words 0 to 7 hold the address registers in their low-order bits, and the upper bits of words 0 to 5 hold control fields: program address, code base and limit, exchange address, vector length, flags, and data base and limit. The sequencer moves whole words and does not interpret any field. The register file offers the present state as one wide vector and receives the new state the same way. Word k occupies bits 64k+63 down to 64k in both vectors.

When reset is released, the block runs one exchange by itself at address 0. This loads the boot context without any external request.

Top module: `ctx_xchg_seq`

## Requirements
- R1: While rst_n is low, mem_req_o, mem_we_o, load_o and done_o are all 0.
- R2: After reset is released, an exchange at base address 0 starts without any start_i pulse. Its loaded state equals the 16 words that memory held at addresses 0 to 15 before the exchange.
- R3: In the read phase, the block requests reads (mem_we_o = 0) at addresses base+0 to base+15 in ascending order. One word moves per cycle in which mem_req_o and mem_gnt_i are both 1, and mem_rdata_i is sampled in that cycle. Without a grant, the request and the address hold.
- R4: No write request is issued until all 16 read grants of the exchange have occurred.
- R5: In the write phase, the block writes word k of cur_state_i to address base+k for k = 0 to 15 in ascending order, with mem_we_o = 1 and one word moved per grant.
- R6: load_o is high for exactly one cycle, in the cycle after the 16th write grant. In that cycle load_data_o carries the 16 words read in the read phase, word k at bits 64k+63:64k.
- R7: done_o is high for exactly one cycle, in the cycle after load_o. In the next cycle the block is idle again.
- R8: A start_i pulse that arrives while an exchange is running (from the first request through the done cycle) is ignored. Its address is never accessed and no further exchange follows.
- R9: start_i in the idle state captures xaddr_i as the base. The first read request appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Exchange request, taken only when idle |
| xaddr_i | input | ADDR_W | Packet base word address for the request |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | 64 | Write data |
| mem_gnt_i | input | 1 | Grant; one word moves per granted cycle |
| mem_rdata_i | input | 64 | Read data, valid in the granted cycle |
| cur_state_i | input | 1024 | Present register state, packet order |
| load_o | output | 1 | Commit strobe to the register file |
| load_data_o | output | 1024 | New state, packet order |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a stalled handshake at the boundary between reading and writing. The bench has to show that no write slips in before the sixteenth read grant, and that the stall cannot move an address. To cover this, the grant line is driven in three patterns: always granted, granted every third cycle, and granted at random. A start request is also injected in the middle of an exchange with an address different from the active one. The behavioural model tracks every beat and compares the outputs in every cycle. The memory contents after each exchange are checked against the state that was offered and the packet that was loaded.

// File: rtl/ctx_xchg_pkg.sv
// Shared types for the context exchange sequencer.
package ctx_xchg_pkg;
    typedef enum logic [2:0] {
        XS_IDLE,
        XS_READ,
        XS_WRITE,
        XS_COMMIT,
        XS_DONE
    } xs_state_t;
endpackage

// File: rtl/ctx_xchg_fsm.sv
// Phase controller: walks the phases IDLE, READ, WRITE, COMMIT and DONE.
// Within READ and WRITE, a beat counter advances on each memory grant.
// Assumes go_i is only meaningful in IDLE.
module ctx_xchg_fsm
    import ctx_xchg_pkg::*;
#(
    parameter int PKT_WORDS = 16,
    parameter int BEAT_W    = $clog2(PKT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              gnt_i,
    output xs_state_t         state_o,
    output logic [BEAT_W-1:0] beat_o
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(PKT_WORDS - 1);

    xs_state_t         state_q;
    logic [BEAT_W-1:0] beat_q;
    logic              last;

    assign last = (beat_q == LAST_BEAT);

    // Phase and beat register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            beat_q  <= '0;
        end else begin
            case (state_q)
                XS_IDLE: begin
                    beat_q <= '0;
                    if (go_i) state_q <= XS_READ;
                end
                XS_READ: begin
                    if (gnt_i) begin
                        beat_q <= last ? '0 : beat_q + 1'b1;
                        if (last) state_q <= XS_WRITE;
                    end
                end
                XS_WRITE: begin
                    if (gnt_i) begin
                        beat_q <= last ? '0 : beat_q + 1'b1;
                        if (last) state_q <= XS_COMMIT;
                    end
                end
                XS_COMMIT: state_q <= XS_DONE;
                default:   state_q <= XS_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign beat_o  = beat_q;
endmodule

// File: rtl/ctx_xchg_buf.sv
// Holding buffer for the incoming packet: one register per packet word,
// each written when its index is selected. The whole buffer is always
// visible as one flat vector in packet order.
module ctx_xchg_buf #(
    parameter int WORD_W    = 64,
    parameter int PKT_WORDS = 16,
    parameter int BEAT_W    = $clog2(PKT_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [BEAT_W-1:0]           wr_idx_i,
    input  logic [WORD_W-1:0]           wr_data_i,
    output logic [WORD_W*PKT_WORDS-1:0] pkt_o
);
    for (genvar g = 0; g < PKT_WORDS; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;

        // Capture one packet word when its index is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                        slot_q <= '0;
            else if (wr_en_i && (wr_idx_i == BEAT_W'(g)))      slot_q <= wr_data_i;
        end

        assign pkt_o[g*WORD_W +: WORD_W] = slot_q;
    end
endmodule

// File: rtl/ctx_xchg_seq.sv
// Context exchange sequencer (top).
// Reads a packet into the buffer, writes the present state back over it,
// then strobes the buffered packet into the register file, and finally
// pulses done. Runs one exchange at base 0 after reset.
// Assumes the register file holds cur_state_i steady during an exchange,
// and that mem_rdata_i is valid in the cycle of a read grant.
module ctx_xchg_seq
    import ctx_xchg_pkg::*;
#(
    parameter int WORD_W    = 64,
    parameter int PKT_WORDS = 16,
    parameter int ADDR_W    = 22
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [ADDR_W-1:0]           xaddr_i,
    output logic                        mem_req_o,
    output logic                        mem_we_o,
    output logic [ADDR_W-1:0]           mem_addr_o,
    output logic [WORD_W-1:0]           mem_wdata_o,
    input  logic                        mem_gnt_i,
    input  logic [WORD_W-1:0]           mem_rdata_i,
    input  logic [WORD_W*PKT_WORDS-1:0] cur_state_i,
    output logic                        load_o,
    output logic [WORD_W*PKT_WORDS-1:0] load_data_o,
    output logic                        done_o
);
    localparam int BEAT_W = $clog2(PKT_WORDS);

    xs_state_t         state;
    logic [BEAT_W-1:0] beat;
    logic              boot_pend_q;
    logic [ADDR_W-1:0] base_q;
    logic              go;

    assign go = (state == XS_IDLE) && (boot_pend_q || start_i);

    // Boot request flag and base address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_pend_q <= 1'b1;
            base_q      <= '0;
        end else if (go) begin
            base_q      <= boot_pend_q ? '0 : xaddr_i;
            boot_pend_q <= 1'b0;
        end
    end

    ctx_xchg_fsm #(.PKT_WORDS(PKT_WORDS), .BEAT_W(BEAT_W)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .gnt_i   (mem_gnt_i),
        .state_o (state),
        .beat_o  (beat)
    );

    ctx_xchg_buf #(.WORD_W(WORD_W), .PKT_WORDS(PKT_WORDS), .BEAT_W(BEAT_W)) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   ((state == XS_READ) && mem_gnt_i),
        .wr_idx_i  (beat),
        .wr_data_i (mem_rdata_i),
        .pkt_o     (load_data_o)
    );

    // Memory side and register-file side outputs.
    assign mem_req_o   = (state == XS_READ) || (state == XS_WRITE);
    assign mem_we_o    = (state == XS_WRITE);
    assign mem_addr_o  = base_q + ADDR_W'(beat);
    assign mem_wdata_o = cur_state_i[beat*WORD_W +: WORD_W];
    assign load_o      = (state == XS_COMMIT);
    assign done_o      = (state == XS_DONE);
endmodule

// File: rtl/ctx_xchg_chk.sv
// Protocol checker for ctx_xchg_seq. It watches only the ports and
// counts read grants itself.
module ctx_xchg_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic              mem_gnt_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              load_o,
    input logic              done_o
);
    logic [4:0] rd_cnt_q;

    // Count read grants of the current exchange.
    always_ff @(posedge clk) begin
        if (!rst_n || done_o)                       rd_cnt_q <= '0;
        else if (mem_req_o && !mem_we_o && mem_gnt_i) rd_cnt_q <= rd_cnt_q + 1'b1;
    end

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !(mem_req_o || load_o || done_o) || rst_n);

    a_r3_hold_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    a_r4_reads_before_writes: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_we_o |-> rd_cnt_q == 5'd16);

    a_r6_load_after_last_write: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> $past(mem_req_o && mem_we_o && mem_gnt_i));

    a_r6_exclusive_phases: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_o, done_o, mem_req_o}));

    a_r7_done_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> done_o);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !mem_req_o);
endmodule

bind ctx_xchg_seq ctx_xchg_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_gnt_i  (mem_gnt_i),
    .mem_addr_o (mem_addr_o),
    .load_o     (load_o),
    .done_o     (done_o)
);

// File: tb/ctx_xchg_seq_tb.sv
// Bench for ctx_xchg_seq: a behavioural memory, a grant driver and a
// cycle-level reference model that is compared on every falling edge.
module ctx_xchg_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] xaddr_i = '0;
    logic          mem_req_o, mem_we_o, mem_gnt_i, load_o, done_o;
    logic [AW-1:0] mem_addr_o;
    logic [63:0]   mem_wdata_o, mem_rdata_i;
    logic [1023:0] cur_state = '0;
    logic [1023:0] load_data_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int gmode = 0;

    logic [63:0] mem [0:255];
    assign mem_rdata_i = mem[mem_addr_o[7:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_xchg_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .xaddr_i(xaddr_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i), .mem_rdata_i(mem_rdata_i),
        .cur_state_i(cur_state), .load_o(load_o), .load_data_o(load_data_o),
        .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Memory write on a granted write request.
    always @(posedge clk)
        if (rst_n && mem_req_o && mem_we_o && mem_gnt_i) mem[mem_addr_o[7:0]] <= mem_wdata_o;

    // Grant driver, changes on the falling edge.
    always @(negedge clk) begin
        cyc++;
        case (gmode)
            0:       mem_gnt_i <= 1'b1;
            1:       mem_gnt_i <= (cyc % 3 == 0);
            default: mem_gnt_i <= 1'($urandom % 2);
        endcase
    end

    // Reference model: phase 0 idle, 1 read, 2 write, 3 commit, 4 done.
    int          m_ph = 0, m_beat = 0, m_base = 0;
    bit          m_boot = 1;
    logic [63:0] m_buf [16];
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_beat = 0; m_base = 0; m_boot = 1;
        end else begin
            case (m_ph)
                0: if (m_boot || start_i) begin
                       m_base = m_boot ? 0 : int'(xaddr_i);
                       m_boot = 0; m_ph = 1; m_beat = 0;
                   end
                1: if (mem_gnt_i) begin
                       m_buf[m_beat] = mem[(m_base + m_beat) & 255];
                       if (m_beat == 15) begin m_ph = 2; m_beat = 0; end
                       else m_beat++;
                   end
                2: if (mem_gnt_i) begin
                       if (m_beat == 15) begin m_ph = 3; m_beat = 0; end
                       else m_beat++;
                   end
                3: m_ph = 4;
                default: m_ph = 0;
            endcase
        end
    end

    // Per-cycle comparison against the model.
    logic [1023:0] lat_load;
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(!(mem_req_o || mem_we_o || load_o || done_o), "R1 reset outputs",
                {60'd0, mem_req_o, mem_we_o, load_o, done_o}, 64'd0);
        end else begin
            chk(mem_req_o == (m_ph == 1 || m_ph == 2), "R3 request", 64'(mem_req_o),
                64'(m_ph == 1 || m_ph == 2));
            if (m_ph == 1) begin
                chk(!mem_we_o, "R4 no write while reading", 64'(mem_we_o), 64'd0);
                chk(int'(mem_addr_o) == m_base + m_beat, "R3 read address",
                    64'(mem_addr_o), 64'(m_base + m_beat));
            end
            if (m_ph == 2) begin
                chk(mem_we_o, "R5 write enable", 64'(mem_we_o), 64'd1);
                chk(int'(mem_addr_o) == m_base + m_beat, "R5 write address",
                    64'(mem_addr_o), 64'(m_base + m_beat));
                chk(mem_wdata_o == cur_state[m_beat*64 +: 64], "R5 write data",
                    mem_wdata_o, cur_state[m_beat*64 +: 64]);
            end
            chk(load_o == (m_ph == 3), "R6 load strobe", 64'(load_o), 64'(m_ph == 3));
            if (m_ph == 3) begin
                for (int k = 0; k < 16; k++)
                    chk(load_data_o[k*64 +: 64] == m_buf[k], "R6 load word",
                        load_data_o[k*64 +: 64], m_buf[k]);
            end
            if (load_o) lat_load = load_data_o;
            chk(done_o == (m_ph == 4), "R7 done pulse", 64'(done_o), 64'(m_ph == 4));
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [63:0] pat(input int seed, input int k);
        return {32'(seed * 7919 + k), 32'(k * 31 + seed)};
    endfunction

    task automatic wait_done();
        while (done_o !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    // Run one exchange and check the memory and the loaded packet against
    // values computed before it began.
    task automatic run_xchg(input int base, input int seed, input int gm,
                            input bit intrude, input int bad_base);
        logic [63:0] old [16];
        logic [63:0] bad_old [16];
        gmode = gm;
        for (int k = 0; k < 16; k++) cur_state[k*64 +: 64] = pat(seed, k);
        for (int k = 0; k < 16; k++) old[k] = mem[base + k];
        for (int k = 0; k < 16; k++) bad_old[k] = mem[bad_base + k];
        start_i = 1'b1; xaddr_i = AW'(base);
        @(negedge clk);
        start_i = 1'b0;
        chk(mem_req_o && int'(mem_addr_o) == base, "R9 first request",
            64'(mem_addr_o), 64'(base));
        if (intrude) begin
            repeat (5) @(negedge clk);
            start_i = 1'b1; xaddr_i = AW'(bad_base);
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_done();
        for (int k = 0; k < 16; k++) begin
            chk(mem[base + k] == pat(seed, k), "R5 memory holds old state",
                mem[base + k], pat(seed, k));
            chk(lat_load[k*64 +: 64] == old[k], "R6 loaded packet",
                lat_load[k*64 +: 64], old[k]);
        end
        if (intrude) begin
            repeat (4) @(negedge clk);
            chk(!mem_req_o, "R8 no second exchange", 64'(mem_req_o), 64'd0);
            for (int k = 0; k < 16; k++)
                chk(mem[bad_base + k] == bad_old[k], "R8 ignored address untouched",
                    mem[bad_base + k], bad_old[k]);
        end
    endtask

    initial begin
        logic [63:0] boot_old [16];
        for (int i = 0; i < 256; i++) mem[i] = {32'hC0DE0000 + 32'(i), 32'(i * 3)};
        for (int k = 0; k < 16; k++) boot_old[k] = mem[k];
        for (int k = 0; k < 16; k++) cur_state[k*64 +: 64] = pat(1, k);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_done();
        for (int k = 0; k < 16; k++) begin
            chk(lat_load[k*64 +: 64] == boot_old[k], "R2 boot packet from address 0",
                lat_load[k*64 +: 64], boot_old[k]);
            chk(mem[k] == pat(1, k), "R2 boot write-back",
                mem[k], pat(1, k));
        end
        repeat (3) @(negedge clk);
        run_xchg(32, 2, 0, 1'b0, 0);
        run_xchg(64, 3, 1, 1'b1, 160);
        run_xchg(100, 4, 2, 1'b0, 0);
        run_xchg(200, 5, 2, 1'b1, 128);
        run_xchg(32, 6, 1, 1'b0, 0);
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule